// File: doc/BRIEF.md
# Global Histogram Equalisation Engine

This block applies global histogram equalisation to a grayscale image held in an external memory. The image memory has separate read and write addresses and a one-cycle read latency. After a start pulse, the engine clears an internal histogram table. It then reads every pixel once to count how often each gray level occurs. Next it turns the table into a running cumulative count, in place. Finally it reads every pixel a second time and writes its remapped value back to the same address.

The pixel count is a power of two, and it is larger than the number of gray levels. Because of this, the scale factor of levels over pixels is a negative power of two. The multiply and divide of the equalisation formula therefore become a right shift of the cumulative count. The result is truncated and then clipped to the top gray level. A one-cycle completion pulse marks the end of the last write. A surrounding controller uses the block as a one-shot job: it loads the image, pulses start and waits for the pulse.

Top module: `histeq_engine`

## Requirements
- R1: While reset is held and right after it is released, `done`, `mem_re` and `mem_we` are low.
- R2: With `start` low in idle, the block makes no memory access. A `start` raised while a job is running has no effect: the job gives exactly one `done` pulse and the same image. After `done`, the block stays idle and makes no access.
- R3: The count of each gray level is exact, including long runs of identical consecutive pixels. A run of any length adds one per pixel to its bin.
- R4: Each job clears the histogram before it counts. Counts from an earlier job never affect the result of a later one.
- R5: A pixel of level k is replaced by C(k) >> (AREA_LOG - PIX_W), truncated. C(k) is the number of pixels in the image whose level is k or lower.
- R6: When the shifted value is larger than 2^PIX_W - 1, the written value is 2^PIX_W - 1.
- R7: The remap pass writes addresses 0 to 2^AREA_LOG - 1, in ascending order, each exactly once. Each result goes to the address its source pixel was read from, so the image memory holds the output after the job.
- R8: `done` is high for exactly one cycle: the cycle right after the last write.
- R9: The count pass reads addresses 0 to 2^AREA_LOG - 1 in ascending order, one per cycle, before any write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job when the block is idle |
| done | output | 1 | One-cycle pulse after the last remapped pixel is written |
| mem_raddr | output | AREA_LOG | Image read address |
| mem_re | output | 1 | Image read enable; data is returned one cycle later |
| mem_rdata | input | PIX_W | Image read data |
| mem_waddr | output | AREA_LOG | Image write address |
| mem_we | output | 1 | Image write enable |
| mem_wdata | output | PIX_W | Remapped pixel value |

## Verification
A constant image sends every pixel to one bin on consecutive cycles. A wrong count there shows a fault in the read-modify-write forwarding, and the image also drives the single level into saturation. A ramp image gives every level the same count, so the result checks the shift amount, the truncation and the clip at the top level. A paired-value image and a pseudo-random image mix short runs with scattered bins. The random run also raises `start` while the job is busy. A two-level image and an image heavily skewed towards level zero run after earlier jobs with different histograms. These two show whether the table is cleared between jobs and whether truncation of uneven cumulative counts is correct.

// File: rtl/histeq_engine.sv
module histeq_engine #(
  parameter int PIX_W    = 8,
  parameter int AREA_LOG = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                done,
  output logic [AREA_LOG-1:0] mem_raddr,
  output logic                mem_re,
  input  logic [PIX_W-1:0]    mem_rdata,
  output logic [AREA_LOG-1:0] mem_waddr,
  output logic                mem_we,
  output logic [PIX_W-1:0]    mem_wdata
);
  localparam int BINS  = 1 << PIX_W;
  localparam int CNT_W = AREA_LOG + 1;
  localparam int SHIFT = AREA_LOG - PIX_W;
  localparam logic [AREA_LOG-1:0] LAST_PIX = {AREA_LOG{1'b1}};
  localparam logic [PIX_W-1:0]    LAST_BIN = {PIX_W{1'b1}};
  localparam logic [CNT_W-1:0]    TOP_LVL  = CNT_W'(BINS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ZERO, S_COUNT, S_CDRAIN, S_CUM, S_REMAP, S_RDRAIN, S_FIN
  } state_t;

  state_t              st;
  logic [AREA_LOG-1:0] idx;
  logic [CNT_W-1:0]    hist [BINS];
  logic [CNT_W-1:0]    acc;
  logic [CNT_W-1:0]    pend_h;
  logic [PIX_W-1:0]    pend_g;
  logic                pend_v;
  logic                cv;
  logic                mv;
  logic [PIX_W-1:0]    bin;
  logic [CNT_W-1:0]    rd_h;
  logic [CNT_W-1:0]    cum_nx;
  logic [CNT_W-1:0]    scaled;

  assign bin       = idx[PIX_W-1:0];
  assign rd_h      = (pend_v && pend_g == mem_rdata) ? pend_h + CNT_W'(1) : hist[mem_rdata];
  assign cum_nx    = acc + hist[bin];
  assign scaled    = hist[mem_rdata] >> SHIFT;
  assign mem_wdata = (scaled > TOP_LVL) ? LAST_BIN : scaled[PIX_W-1:0];
  assign mem_re    = (st == S_COUNT) || (st == S_REMAP);
  assign mem_raddr = idx;
  assign mem_we    = mv;
  assign done      = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (st == S_ZERO)
      hist[bin] <= '0;
    else if (pend_v)
      hist[pend_g] <= pend_h + CNT_W'(1);
    else if (st == S_CUM)
      hist[bin] <= cum_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      acc       <= '0;
      cv        <= 1'b0;
      mv        <= 1'b0;
      pend_v    <= 1'b0;
      pend_g    <= '0;
      pend_h    <= '0;
      mem_waddr <= '0;
    end else begin
      cv        <= (st == S_COUNT);
      mv        <= (st == S_REMAP);
      pend_v    <= cv;
      pend_g    <= mem_rdata;
      pend_h    <= rd_h;
      mem_waddr <= idx;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_ZERO;
          idx <= '0;
        end
        S_ZERO: begin
          idx <= idx + 1'b1;
          if (bin == LAST_BIN) begin
            st  <= S_COUNT;
            idx <= '0;
          end
        end
        S_COUNT: begin
          idx <= idx + 1'b1;
          if (idx == LAST_PIX) st <= S_CDRAIN;
        end
        S_CDRAIN: if (!cv && !pend_v) begin
          st  <= S_CUM;
          idx <= '0;
          acc <= '0;
        end
        S_CUM: begin
          acc <= cum_nx;
          idx <= idx + 1'b1;
          if (bin == LAST_BIN) begin
            st  <= S_REMAP;
            idx <= '0;
          end
        end
        S_REMAP: begin
          idx <= idx + 1'b1;
          if (idx == LAST_PIX) st <= S_RDRAIN;
        end
        S_RDRAIN: st <= S_FIN;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/histeq_engine_chk.sv
module histeq_engine_chk #(
  parameter int PIX_W    = 8,
  parameter int AREA_LOG = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic [AREA_LOG-1:0] mem_raddr,
  input logic                mem_re,
  input logic [AREA_LOG-1:0] mem_waddr,
  input logic                mem_we,
  input logic [PIX_W-1:0]    mem_wdata
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we)); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_re && !mem_we)); // R2
  AST_WRITE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_waddr == $past(mem_waddr) + 1'b1); // R7
  AST_WRITE_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_re) && mem_waddr == $past(mem_raddr))); // R7
  AST_READ_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_raddr == $past(mem_raddr) + 1'b1); // R9
  AST_NO_DONE_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_re); // R8
endmodule

bind histeq_engine histeq_engine_chk #(.PIX_W(PIX_W), .AREA_LOG(AREA_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_raddr(mem_raddr), .mem_re(mem_re),
  .mem_waddr(mem_waddr), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/histeq_engine_test.sv
module histeq_engine_test;
  localparam int PW   = 6;
  localparam int AL   = 10;
  localparam int NP   = 1 << AL;
  localparam int NL   = 1 << PW;
  localparam int Q    = AL - PW;
  localparam int MAXV = NL - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done;
  logic [AL-1:0] mem_raddr, mem_waddr;
  logic          mem_re, mem_we;
  logic [PW-1:0] mem_rdata = '0;
  logic [PW-1:0] mem_wdata;

  logic [PW-1:0] mem [NP];
  logic [PW-1:0] src [NP];
  logic          load_req = 1'b0;
  int            expv [NP];
  bit            satf [NP];
  int            checks = 0;
  int            failures = 0;

  always #4 clk = ~clk;

  histeq_engine #(.PIX_W(PW), .AREA_LOG(AL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mem_raddr(mem_raddr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_waddr(mem_waddr), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < NP; i++) mem[i] <= src[i];
    end else begin
      if (mem_re) mem_rdata <= mem[mem_raddr];
      if (mem_we) mem[mem_waddr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp_i);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_i);
    end
  endtask

  task automatic gen(input int pat);
    int seed = 12345;
    for (int i = 0; i < NP; i++) begin
      case (pat)
        0: src[i] = PW'(37);
        1: src[i] = PW'(i % NL);
        2: src[i] = PW'(((i / 2) * 7) % NL);
        3: begin
          seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
          src[i] = PW'((seed >> 16) % NL);
        end
        4: src[i] = (i % 2 == 0) ? PW'(0) : PW'(MAXV);
        default: src[i] = (i < 1000) ? PW'(0) : PW'(i % 24);
      endcase
    end
  endtask

  task automatic model;
    int h [NL];
    int cdf [NL];
    int acc = 0;
    for (int k = 0; k < NL; k++) h[k] = 0;
    for (int i = 0; i < NP; i++) h[src[i]]++;
    for (int k = 0; k < NL; k++) begin
      acc += h[k];
      cdf[k] = acc >> Q;
    end
    for (int i = 0; i < NP; i++) begin
      satf[i] = cdf[src[i]] > MAXV;
      expv[i] = satf[i] ? MAXV : cdf[src[i]];
    end
  endtask

  task automatic run(input int pat, input string tag, input bit mid_start);
    int rcount = 0;
    int wcount = 0;
    int dones = 0;
    int after = 0;
    int cyc = 0;
    bit prev_we = 1'b0;
    bit prev_done = 1'b0;
    bit finished = 1'b0;
    gen(pat);
    model();
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!finished) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      start = (mid_start && cyc == 500) ? 1'b1 : 1'b0;
      if (mem_re && wcount == 0 && rcount < NP) begin
        chk(mem_raddr == AL'(rcount), "R9", "count-pass read address", int'(mem_raddr), rcount);
        rcount++;
      end
      if (mem_we) begin
        chk(mem_waddr == AL'(wcount), "R7", "write address order", int'(mem_waddr), wcount);
        chk(rcount == NP, "R9", "reads before first write", rcount, NP);
        if (satf[mem_waddr])
          chk(int'(mem_wdata) == expv[mem_waddr], "R6", "saturated pixel", int'(mem_wdata), expv[mem_waddr]);
        else
          chk(int'(mem_wdata) == expv[mem_waddr], tag, "remapped pixel", int'(mem_wdata), expv[mem_waddr]);
        wcount++;
      end
      if (done) begin
        dones++;
        chk(prev_we && wcount == NP, "R8", "done after last write", wcount, NP);
        chk(!prev_done, "R8", "done width", 2, 1);
      end
      if (dones > 0) begin
        if (!done) chk(!mem_re && !mem_we, "R2", "idle after done", int'(mem_re) + int'(mem_we), 0);
        after++;
        if (after > 4) finished = 1'b1;
      end
      if (cyc > 6000) begin
        chk(1'b0, "R8", "watchdog expired", cyc, 6000);
        finished = 1'b1;
      end
      prev_we = mem_we;
      prev_done = done;
    end
    start = 1'b0;
    chk(dones == 1, mid_start ? "R2" : "R8", "done pulses per job", dones, 1);
    for (int i = 0; i < NP; i++)
      if (int'(mem[i]) != expv[i]) begin
        chk(1'b0, "R7", "in-place memory contents", int'(mem[i]), expv[i]);
        break;
      end
    chk(1'b1, "R7", "memory image compared", 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!done && !mem_re && !mem_we, "R1", "outputs in reset", int'(done) + int'(mem_re) + int'(mem_we), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || mem_re || mem_we)
        chk(1'b0, i == 0 ? "R1" : "R2", "idle without start", int'(done) + int'(mem_re) + int'(mem_we), 0);
    end
    chk(1'b1, "R2", "idle window observed", 0, 0);
    run(0, "R3", 1'b0);
    run(1, "R5", 1'b0);
    run(2, "R3", 1'b0);
    run(3, "R5", 1'b1);
    run(4, "R4", 1'b0);
    run(5, "R4", 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule